// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a direct-mapped cache that sits between a processor port and a slower word-wide memory port. Each processor request carries a word address. The address is split into three fields: a word offset within the line, a line index, and a tag. A hit needs the indexed line to be valid and its stored tag to match the tag field. A miss stalls the processor while all words of the line are read from memory. The request is then retried and completes as a hit.

The build-time parameter `WMODE` selects one of three write policies:

- **Write-through** (`WM_THROUGH`): the processor waits for every write to finish at memory.
- **Buffered write-through** (`WM_BUFFERED`): writes are posted into a small queue that empties into memory in the background.
- **Copy-back** (`WM_COPYBACK`): writes stay in the cache and mark the line dirty. A dirty line is written out only when a different block displaces it.

In every mode, a write miss first brings the line in and then writes the word.

**Processor port.** It holds `cpu_req` and its fields stable until `cpu_ready`. `cpu_ready` rises in the cycle the access completes and stays low through every stall.

**Memory port.** It is valid/ready. The cache holds `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready`. A transfer happens in a cycle where both are high. For reads, `mem_rdata` is sampled in that cycle. The memory may take any number of cycles to answer.

Top module: `dmc_top`

## Requirements
- R1: After reset every line is invalid. The first access to any address misses, and with no request the block drives `cpu_ready` and `mem_valid` low.
- R2: The address layout is: word offset in bits [1:0], line index in bits [4:2], tag in bits [7:5]. An access hits only when the indexed line is valid and its tag matches. A different block at the same index misses and replaces the line.
- R3: A read hit raises `cpu_ready` in the same cycle as the request, with the addressed word on `cpu_rdata`.
- R4: On a read miss the processor stalls while the four words of the line are read from memory at offsets 0, 1, 2, 3 in that order. Afterwards every word of the line hits with memory's data.
- R5: With 8 lines of 4 words, misses to blocks 10110, 11010, 10000, 00011 and 10010 fill indices 110, 010, 000, 011 and 010. The last of these displaces block 11010, while the other three stay resident.
- R6: Write-through: a write hit updates the cached word and issues one memory write. `cpu_ready` rises only in the cycle that memory accepts it.
- R7: Buffered write-through: a write hit with queue space completes with no wait, and the queued write reaches memory without further processor action.
- R8: Buffered write-through: with 4 queued writes outstanding, a further write stalls until an entry has drained.
- R9: Buffered write-through: a line fill does not start while any posted write is still queued, so a fill returns data written earlier.
- R10: Copy-back: a write hit completes with no wait, updates only the cache and issues no memory write.
- R11: Copy-back: a miss on a dirty line first writes its four words back to memory, then fills the new block. The refilled line is clean, so displacing it later issues no memory write.
- R12: A write miss fills the line, then writes the word. Later reads of that word and of its neighbours hit.
- R13: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on a read |
| cpu_ready | output | 1 | Access completes this cycle |
| mem_valid | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ready | input | 1 | Memory accepts or answers this cycle |
| mem_rdata | input | DATA_W | Memory read data, sampled with mem_ready |

## Verification
The same access script runs against all three write policies.

- **Fill pattern.** The five-block sequence shows that the index is taken from the right bits and that a tag mismatch replaces a line, while neighbours at other indices survive.
- **Write hit.** A write hit to a resident line separates the policies by stall length, by when memory changes and by the memory write count. A later miss on the same index shows whether a dirty line is written back, and whether the refill is clean.
- **Write miss.** A write to a never-used index checks fill-then-write.
- **Queue limit.** Under slow memory, a run of five queued writes shows the stall at the queue limit.
- **Read after posted writes.** A read miss straight after those writes shows that stale memory data is never fetched.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    WM_THROUGH  = 2'd0,
    WM_BUFFERED = 2'd1,
    WM_COPYBACK = 2'd2
  } wmode_e;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_EVICT  = 2'd1,
    ST_FILL   = 2'd2
  } cst_e;
endpackage

// File: rtl/dmc_store.sv
// Tag, valid, dirty and data arrays of the direct-mapped cache.
module dmc_store #(
  parameter int LINES  = 8,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic [OFF_W-1:0]  ev_off,
  output logic              line_vld,
  output logic              line_dty,
  output logic [TAG_W-1:0]  line_tag,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ev_word,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              fill_done,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              mark_dirty
);
  logic [DATA_W-1:0] words [LINES][WORDS];
  logic [TAG_W-1:0]  tags  [LINES];
  logic [LINES-1:0]  vld, dty;

  assign line_vld = vld[idx];
  assign line_dty = dty[idx];
  assign line_tag = tags[idx];
  assign rd_word  = words[idx][rd_off];
  assign ev_word  = words[idx][ev_off];

  always_ff @(posedge clk) begin
    if (wr_en) words[idx][wr_off] <= wr_word;
    if (fill_done) tags[idx] <= fill_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      dty <= '0;
    end else if (fill_done) begin
      vld[idx] <= 1'b1;
      dty[idx] <= 1'b0;
    end else if (mark_dirty) begin
      dty[idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/dmc_wbuf.sv
// Posted-write queue for buffered write-through.
module dmc_wbuf #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  output logic              full,
  output logic              empty,
  output logic              m_valid,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_data,
  input  logic              m_ready
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] q_addr [DEPTH];
  logic [DATA_W-1:0] q_data [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt;
  logic              pop;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign m_valid = !empty;
  assign m_addr  = q_addr[rp];
  assign m_data  = q_data[rp];
  assign pop     = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wp] <= push_addr;
      q_data[wp] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/dmc_ctrl.sv
// Lookup, eviction and fill sequencing.
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter wmode_e WMODE  = WM_COPYBACK,
  parameter int     ADDR_W = 8,
  parameter int     DATA_W = 16,
  parameter int     WORDS  = 4,
  parameter int     IDX_W  = 3,
  parameter int     OFF_W  = 2,
  parameter int     TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [IDX_W-1:0]  idx,
  output logic [OFF_W-1:0]  rd_off,
  output logic [OFF_W-1:0]  ev_off,
  input  logic              line_vld,
  input  logic              line_dty,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] ev_word,
  output logic              wr_en,
  output logic [OFF_W-1:0]  wr_off,
  output logic [DATA_W-1:0] wr_word,
  output logic              fill_done,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              mark_dirty,
  input  logic              wb_full,
  input  logic              wb_empty,
  output logic              wb_push,
  output logic              m_valid,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_ready,
  input  logic [DATA_W-1:0] m_rdata
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  cst_e             st, st_n;
  logic [OFF_W-1:0] beat, beat_n;
  logic [OFF_W-1:0] a_off;
  logic [TAG_W-1:0] a_tag;
  logic             hit, fill_blocked;

  assign a_off    = cpu_addr[OFF_W-1:0];
  assign idx      = cpu_addr[OFF_W +: IDX_W];
  assign a_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
  assign rd_off   = a_off;
  assign ev_off   = beat;
  assign fill_tag = a_tag;
  assign hit      = line_vld && (line_tag == a_tag);
  assign fill_blocked = (WMODE == WM_BUFFERED) && !wb_empty;

  always_comb begin
    st_n       = st;
    beat_n     = beat;
    cpu_ready  = 1'b0;
    wr_en      = 1'b0;
    wr_off     = a_off;
    wr_word    = cpu_wdata;
    fill_done  = 1'b0;
    mark_dirty = 1'b0;
    wb_push    = 1'b0;
    m_valid    = 1'b0;
    m_we       = 1'b0;
    m_addr     = cpu_addr;
    m_wdata    = cpu_wdata;
    unique case (st)
      ST_LOOKUP: begin
        if (cpu_req && hit) begin
          if (!cpu_we) begin
            cpu_ready = 1'b1;
          end else if (WMODE == WM_THROUGH) begin
            m_valid = 1'b1;
            m_we    = 1'b1;
            if (m_ready) begin
              cpu_ready = 1'b1;
              wr_en     = 1'b1;
            end
          end else if (WMODE == WM_BUFFERED) begin
            if (!wb_full) begin
              wb_push   = 1'b1;
              wr_en     = 1'b1;
              cpu_ready = 1'b1;
            end
          end else begin
            wr_en      = 1'b1;
            mark_dirty = 1'b1;
            cpu_ready  = 1'b1;
          end
        end else if (cpu_req && !fill_blocked) begin
          beat_n = '0;
          st_n   = (WMODE == WM_COPYBACK && line_vld && line_dty) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        m_valid = 1'b1;
        m_we    = 1'b1;
        m_addr  = {line_tag, idx, beat};
        m_wdata = ev_word;
        if (m_ready) begin
          beat_n = beat + 1'b1;
          if (beat == LAST) st_n = ST_FILL;
        end
      end
      ST_FILL: begin
        m_valid = 1'b1;
        m_addr  = {a_tag, idx, beat};
        if (m_ready) begin
          wr_en   = 1'b1;
          wr_off  = beat;
          wr_word = m_rdata;
          beat_n  = beat + 1'b1;
          if (beat == LAST) begin
            fill_done = 1'b1;
            st_n      = ST_LOOKUP;
          end
        end
      end
      default: st_n = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_LOOKUP;
      beat <= '0;
    end else begin
      st   <= st_n;
      beat <= beat_n;
    end
  end
endmodule

// File: rtl/dmc_top.sv
module dmc_top
  import dmc_pkg::*;
#(
  parameter wmode_e WMODE    = WM_COPYBACK,
  parameter int     ADDR_W   = 8,
  parameter int     DATA_W   = 16,
  parameter int     LINES    = 8,
  parameter int     WORDS    = 4,
  parameter int     WB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0]  idx;
  logic [OFF_W-1:0]  rd_off, ev_off, wr_off;
  logic              line_vld, line_dty, wr_en, fill_done, mark_dirty;
  logic [TAG_W-1:0]  line_tag, fill_tag;
  logic [DATA_W-1:0] ev_word, wr_word;
  logic              wb_full, wb_empty, wb_push;
  logic              c_valid, c_we;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_wdata;
  logic              b_valid, b_ready;
  logic [ADDR_W-1:0] b_addr;
  logic [DATA_W-1:0] b_data;

  dmc_store #(
    .LINES(LINES), .WORDS(WORDS), .IDX_W(IDX_W), .OFF_W(OFF_W),
    .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .idx(idx), .rd_off(rd_off), .ev_off(ev_off),
    .line_vld(line_vld), .line_dty(line_dty), .line_tag(line_tag),
    .rd_word(cpu_rdata), .ev_word(ev_word),
    .wr_en(wr_en), .wr_off(wr_off), .wr_word(wr_word),
    .fill_done(fill_done), .fill_tag(fill_tag), .mark_dirty(mark_dirty)
  );

  dmc_ctrl #(
    .WMODE(WMODE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
    .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready),
    .idx(idx), .rd_off(rd_off), .ev_off(ev_off),
    .line_vld(line_vld), .line_dty(line_dty), .line_tag(line_tag), .ev_word(ev_word),
    .wr_en(wr_en), .wr_off(wr_off), .wr_word(wr_word),
    .fill_done(fill_done), .fill_tag(fill_tag), .mark_dirty(mark_dirty),
    .wb_full(wb_full), .wb_empty(wb_empty), .wb_push(wb_push),
    .m_valid(c_valid), .m_we(c_we), .m_addr(c_addr), .m_wdata(c_wdata),
    .m_ready(mem_ready), .m_rdata(mem_rdata)
  );

  if (WMODE == WM_BUFFERED) begin : g_wbuf
    dmc_wbuf #(.DEPTH(WB_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .push(wb_push), .push_addr(cpu_addr), .push_data(cpu_wdata),
      .full(wb_full), .empty(wb_empty),
      .m_valid(b_valid), .m_addr(b_addr), .m_data(b_data), .m_ready(b_ready)
    );
  end else begin : g_nobuf
    logic nobuf_unused;
    assign nobuf_unused = wb_push ^ b_ready;
    assign wb_full  = 1'b0;
    assign wb_empty = 1'b1;
    assign b_valid  = 1'b0;
    assign b_addr   = '0;
    assign b_data   = '0;
  end

  // Controller traffic and queue drain never overlap; controller wins if both.
  assign mem_valid = c_valid | b_valid;
  assign mem_we    = c_valid ? c_we : b_valid;
  assign mem_addr  = c_valid ? c_addr : b_addr;
  assign mem_wdata = c_valid ? c_wdata : b_data;
  assign b_ready   = mem_ready & ~c_valid;
endmodule

// File: rtl/dmc_chk.sv
module dmc_chk
  import dmc_pkg::*;
#(
  parameter wmode_e WMODE  = WM_COPYBACK,
  parameter int     ADDR_W = 8,
  parameter int     DATA_W = 16,
  parameter int     OFF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              mem_valid,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              wb_full,
  input logic              wb_empty
);
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R13

  AST_FILL_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_we && (mem_addr[OFF_W-1:0] != '1)
    |=> mem_valid && !mem_we && (mem_addr == $past(mem_addr) + 1'b1)); // R4

  AST_THROUGH_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (WMODE == WM_THROUGH) && cpu_req && cpu_we && cpu_ready |-> mem_valid && mem_we && mem_ready); // R6

  AST_QUEUE_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full && cpu_req && cpu_we |-> !cpu_ready); // R8

  AST_NO_READ_PAST_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_empty |-> !(mem_valid && !mem_we)); // R9

  AST_COPYBACK_SILENT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (WMODE == WM_COPYBACK) && cpu_req && cpu_we && cpu_ready |-> !mem_valid); // R10

  AST_EVICT_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    (WMODE == WM_COPYBACK) && mem_valid && mem_we && mem_ready && (mem_addr[OFF_W-1:0] != '1)
    |=> mem_valid && mem_we); // R11
endmodule

bind dmc_top dmc_chk #(
  .WMODE(WMODE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready), .wb_full(wb_full), .wb_empty(wb_empty)
);

// File: tb/tb_dmc_top.sv
module tb_dmc_top;
  import dmc_pkg::*;
  localparam int NL = 3;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          cpu_req [NL];
  logic          cpu_we [NL];
  logic          cpu_ready [NL];
  logic [AW-1:0] cpu_addr [NL];
  logic [DW-1:0] cpu_wdata [NL];
  logic [DW-1:0] cpu_rdata [NL];
  logic          mem_valid [NL];
  logic          mem_we [NL];
  logic          mem_ready [NL];
  logic [AW-1:0] mem_addr [NL];
  logic [DW-1:0] mem_wdata [NL];
  logic [DW-1:0] mem_rdata [NL];

  logic [DW-1:0] mem_arr [NL][256];
  int            lat_cnt [NL];
  int            wr_cnt [NL];
  bit            slow [NL];

  int total = 0;
  int bad = 0;

  typedef struct { int ln; logic [DW-1:0] val; } sb_t;
  sb_t sb_q[$];

  function automatic logic [DW-1:0] memv(int l, int a);
    return DW'(a * 97 + l * 4096 + 769);
  endfunction

  function automatic logic [AW-1:0] wa(logic [4:0] b, logic [1:0] o);
    return {1'b0, b, o};
  endfunction

  for (genvar i = 0; i < NL; i++) begin : g_lane
    dmc_top #(.WMODE(wmode_e'(i))) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req[i]), .cpu_we(cpu_we[i]), .cpu_addr(cpu_addr[i]),
      .cpu_wdata(cpu_wdata[i]), .cpu_rdata(cpu_rdata[i]), .cpu_ready(cpu_ready[i]),
      .mem_valid(mem_valid[i]), .mem_we(mem_we[i]), .mem_addr(mem_addr[i]),
      .mem_wdata(mem_wdata[i]), .mem_ready(mem_ready[i]), .mem_rdata(mem_rdata[i])
    );
  end

  // Memory model with address-dependent or long latency.
  always_comb begin
    for (int l = 0; l < NL; l++) begin
      mem_ready[l] = mem_valid[l] && (lat_cnt[l] >= (slow[l] ? 20 : int'(mem_addr[l][1:0])));
      mem_rdata[l] = mem_arr[l][mem_addr[l]];
    end
  end

  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      if (!rst_n) begin
        lat_cnt[l] <= 0;
        wr_cnt[l]  <= 0;
        for (int a = 0; a < 256; a++) mem_arr[l][a] <= memv(l, a);
      end else if (mem_valid[l]) begin
        if (mem_ready[l]) begin
          lat_cnt[l] <= 0;
          if (mem_we[l]) begin
            mem_arr[l][mem_addr[l]] <= mem_wdata[l];
            wr_cnt[l] <= wr_cnt[l] + 1;
          end
        end else begin
          lat_cnt[l] <= lat_cnt[l] + 1;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: reads completing at the processor port.
  always @(negedge clk) begin
    sb_t e;
    #2;
    for (int l = 0; l < NL; l++) begin
      if (rst_n && cpu_req[l] && cpu_ready[l] && !cpu_we[l]) begin
        if (sb_q.size() == 0) chk(1'b0, "R3 unexpected read", int'(cpu_rdata[l]), 0);
        else begin
          e = sb_q.pop_front();
          chk(e.ln == l && cpu_rdata[l] == e.val, "R3 read data", int'(cpu_rdata[l]), int'(e.val));
        end
      end
    end
  end

  // Memory request hold rule (R13).
  logic          prev_wait [NL];
  logic [AW-1:0] prev_addr [NL];
  logic          prev_we [NL];
  always @(negedge clk) begin
    #3;
    for (int l = 0; l < NL; l++) begin
      if (rst_n && prev_wait[l])
        chk(mem_valid[l] && mem_addr[l] == prev_addr[l] && mem_we[l] == prev_we[l],
            "R13 request held", int'(mem_addr[l]), int'(prev_addr[l]));
      prev_wait[l] = rst_n && mem_valid[l] && !mem_ready[l];
      prev_addr[l] = mem_addr[l];
      prev_we[l]   = mem_we[l];
    end
  end

  task automatic access(int ln, bit we, logic [AW-1:0] a, logic [DW-1:0] d, output int cyc);
    sb_t e;
    @(negedge clk);
    if (!we) begin
      e.ln = ln; e.val = d;
      sb_q.push_back(e);
    end
    cpu_req[ln] = 1'b1; cpu_we[ln] = we; cpu_addr[ln] = a; cpu_wdata[ln] = we ? d : '0;
    cyc = 0;
    #1;
    while (!cpu_ready[ln]) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    @(negedge clk);
    cpu_req[ln] = 1'b0; cpu_we[ln] = 1'b0;
  endtask

  task automatic run_lane(int ln);
    int cyc, w0;
    logic [4:0] blk [4];
    blk[0] = 5'b11010; blk[1] = 5'b10000; blk[2] = 5'b00011; blk[3] = 5'b10010;
    @(negedge clk); #1;
    chk(!cpu_ready[ln] && !mem_valid[ln], "R1 idle outputs", int'(mem_valid[ln]), 0);
    access(ln, 0, wa(5'b10110, 1), memv(ln, wa(5'b10110, 1)), cyc);
    chk(cyc > 0, "R1 first access misses", cyc, 1);
    access(ln, 0, wa(5'b10110, 1), memv(ln, wa(5'b10110, 1)), cyc);
    chk(cyc == 0, "R3 read hit no wait", cyc, 0);
    access(ln, 0, wa(5'b10110, 0), memv(ln, wa(5'b10110, 0)), cyc);
    chk(cyc == 0, "R4 line word 0 filled", cyc, 0);
    access(ln, 0, wa(5'b10110, 3), memv(ln, wa(5'b10110, 3)), cyc);
    chk(cyc == 0, "R2 same line other offset hits", cyc, 0);
    for (int k = 0; k < 4; k++) begin
      access(ln, 0, wa(blk[k], 2), memv(ln, wa(blk[k], 2)), cyc);
      chk(cyc > 0, "R5 sequence miss", cyc, 1);
    end
    access(ln, 0, wa(5'b10110, 2), memv(ln, wa(5'b10110, 2)), cyc);
    chk(cyc == 0, "R5 index 110 kept", cyc, 0);
    access(ln, 0, wa(5'b10000, 0), memv(ln, wa(5'b10000, 0)), cyc);
    chk(cyc == 0, "R5 index 000 kept", cyc, 0);
    access(ln, 0, wa(5'b00011, 1), memv(ln, wa(5'b00011, 1)), cyc);
    chk(cyc == 0, "R5 index 011 kept", cyc, 0);
    access(ln, 0, wa(5'b11010, 2), memv(ln, wa(5'b11010, 2)), cyc);
    chk(cyc > 0, "R2 tag mismatch at index 010 misses", cyc, 1);
    chk(wr_cnt[ln] == 0, "R4 reads issue no memory writes", wr_cnt[ln], 0);

    w0 = wr_cnt[ln];
    access(ln, 1, wa(5'b11010, 2), 16'hBEEF, cyc);
    if (ln == 0) begin
      chk(cyc > 0, "R6 write waits for memory", cyc, 1);
      chk(mem_arr[ln][wa(5'b11010, 2)] == 16'hBEEF, "R6 memory written at completion",
          int'(mem_arr[ln][wa(5'b11010, 2)]), 16'hBEEF);
    end else if (ln == 1) begin
      chk(cyc == 0, "R7 posted write no wait", cyc, 0);
    end else begin
      chk(cyc == 0, "R10 copy-back write no wait", cyc, 0);
    end
    repeat (10) @(negedge clk);
    if (ln == 2) begin
      chk(mem_arr[ln][wa(5'b11010, 2)] == memv(ln, wa(5'b11010, 2)), "R10 memory untouched",
          int'(mem_arr[ln][wa(5'b11010, 2)]), int'(memv(ln, wa(5'b11010, 2))));
      chk(wr_cnt[ln] == w0, "R10 no memory write", wr_cnt[ln], w0);
    end else begin
      chk(mem_arr[ln][wa(5'b11010, 2)] == 16'hBEEF, ln == 1 ? "R7 queue drained" : "R6 memory holds write",
          int'(mem_arr[ln][wa(5'b11010, 2)]), 16'hBEEF);
      chk(wr_cnt[ln] == w0 + 1, ln == 1 ? "R7 one memory write" : "R6 one memory write", wr_cnt[ln], w0 + 1);
    end
    access(ln, 0, wa(5'b11010, 2), 16'hBEEF, cyc);
    chk(cyc == 0, "R10 cached word updated", cyc, 0);

    access(ln, 0, wa(5'b10010, 0), memv(ln, wa(5'b10010, 0)), cyc);
    chk(wr_cnt[ln] == w0 + ((ln == 2) ? 4 : 1), "R11 write-back count", wr_cnt[ln], w0 + ((ln == 2) ? 4 : 1));
    chk(mem_arr[ln][wa(5'b11010, 2)] == 16'hBEEF, "R11 dirty word in memory",
        int'(mem_arr[ln][wa(5'b11010, 2)]), 16'hBEEF);
    access(ln, 0, wa(5'b11010, 2), 16'hBEEF, cyc);
    chk(cyc > 0, "R11 refetch after eviction", cyc, 1);
    w0 = wr_cnt[ln];
    access(ln, 0, wa(5'b10010, 1), memv(ln, wa(5'b10010, 1)), cyc);
    chk(wr_cnt[ln] == w0, "R11 refilled line is clean", wr_cnt[ln], w0);

    access(ln, 1, wa(5'b00101, 1), 16'h1234, cyc);
    chk(cyc > 0, "R12 write miss fills first", cyc, 1);
    access(ln, 0, wa(5'b00101, 1), 16'h1234, cyc);
    chk(cyc == 0, "R12 written word hits", cyc, 0);
    access(ln, 0, wa(5'b00101, 3), memv(ln, wa(5'b00101, 3)), cyc);
    chk(cyc == 0, "R12 neighbour word hits", cyc, 0);

    if (ln == 1) begin
      repeat (10) @(negedge clk);
      slow[ln] = 1'b1;
      for (int k = 0; k < 4; k++) begin
        access(ln, 1, wa(5'b00101, 2'(k)), 16'hC000 + 16'(k), cyc);
        chk(cyc == 0, "R8 queue has space", cyc, 0);
      end
      access(ln, 1, wa(5'b00101, 0), 16'hC004, cyc);
      chk(cyc > 0, "R8 full queue stalls", cyc, 1);
      access(ln, 0, wa(5'b10101, 0), memv(ln, wa(5'b10101, 0)), cyc);
      chk(cyc > 0, "R9 miss after posted writes", cyc, 1);
      access(ln, 0, wa(5'b00101, 0), 16'hC004, cyc);
      chk(cyc > 0, "R9 refill sees newest write", cyc, 1);
      access(ln, 0, wa(5'b00101, 1), 16'hC001, cyc);
      chk(cyc == 0, "R9 refilled neighbour", cyc, 0);
      slow[ln] = 1'b0;
    end
  endtask

  initial begin
    for (int l = 0; l < NL; l++) begin
      cpu_req[l] = 1'b0; cpu_we[l] = 1'b0; cpu_addr[l] = '0; cpu_wdata[l] = '0;
      slow[l] = 1'b0; prev_wait[l] = 1'b0; prev_addr[l] = '0; prev_we[l] = 1'b0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < NL; l++) run_lane(l);
    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0, "R3 all reads observed", sb_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule